// File: doc/BRIEF.md
# Dimension-Order Mesh/Torus Route Selector

This block makes the routing decision for one node of a two-dimensional k-ary network. A packet's head flit arrives with destination coordinates. The node knows its own coordinates. For each dimension the block computes a signed offset: the destination coordinate minus the node's coordinate. From these offsets it picks one of five output directions. All movement along X is finished before any movement along Y begins, so a nonzero X offset always wins. When both offsets are zero, the packet is delivered to the local port.

A mode input switches the node between a plain mesh and a torus. In mesh mode the packet always moves toward the destination along the row or column, following the sign of the offset. In torus mode the edges wrap around. The packet then takes whichever way round the ring is shorter. When both ways are exactly half the ring apart, the positive direction is used.

The choice is registered. It appears, with a valid flag, on the clock edge after a head flit is presented, and it feeds an output arbiter.

Top module: `dor_route_unit`

## Requirements
- R1: While reset is asserted and after it is released with no head flit, `port_valid` is 0 and `port_sel` is 0 (local).
- R2: `port_valid` is 1 in exactly the cycle after a cycle in which `head_valid` was 1, and 0 after a cycle in which it was 0.
- R3: If the X coordinates differ, the registered choice is X plus (code 1) or X minus (code 2), whatever the Y coordinates are.
- R4: If the X coordinates are equal and the Y coordinates differ, the choice is Y plus (code 3) or Y minus (code 4).
- R5: If both coordinate pairs are equal, the choice is local (code 0).
- R6: In mesh mode (`torus_mode` = 0) the direction follows the sign of destination minus own coordinate: positive gives plus, negative gives minus, and there is no wraparound.
- R7: In torus mode, when the offset magnitude in the active dimension exceeds RADIX/2, the direction is the opposite of the offset's sign.
- R8: In torus mode, when the offset magnitude equals RADIX/2, the direction is plus.
- R9: In a cycle with `head_valid` = 0, `port_sel` keeps its previous value whatever the coordinate inputs do.
- R10: In torus mode, when the offset magnitude is below RADIX/2, the direction is the same as in mesh mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A head flit with a destination is present this cycle |
| torus_mode | input | 1 | 1 = wraparound links present, 0 = plain mesh |
| here_x | input | CW | This node's X coordinate |
| here_y | input | CW | This node's Y coordinate |
| dest_x | input | CW | Destination X coordinate |
| dest_y | input | CW | Destination Y coordinate |
| port_valid | output | 1 | Registered choice is fresh this cycle |
| port_sel | output | 3 | Chosen port: 0 local, 1 X+, 2 X-, 3 Y+, 4 Y- |

## Verification
Every result is due one rising edge after the head flit is presented. `port_valid` and `port_sel` both change on that edge. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, so exactly one register stage lies between stimulus and check. For the hold behaviour, the bench drops `head_valid` and disturbs the coordinates, then reads the outputs one falling edge later, before any new head flit arrives.

// File: rtl/dor_route_pkg.sv
package dor_route_pkg;

  typedef enum logic [1:0] {
    DIR_NONE  = 2'd0,
    DIR_PLUS  = 2'd1,
    DIR_MINUS = 2'd2
  } step_dir_e;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XN    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YN    = 3'd4
  } out_port_e;

  localparam int NUM_DIMS = 2;

endpackage

// File: rtl/dor_axis_dir.sv
module dor_axis_dir
  import dor_route_pkg::*;
#(
  parameter int RADIX = 8,
  parameter int CW    = (RADIX > 1) ? $clog2(RADIX) : 1
) (
  input  logic [CW-1:0] own_c,
  input  logic [CW-1:0] dst_c,
  input  logic          wrap_en,
  output step_dir_e     dir
);

  // Direction along one axis from a signed offset; shortest way on a ring.
  function automatic step_dir_e pick_dir(input int off, input logic wrap);
    int mag;
    mag = (off < 0) ? -off : off;
    if (off == 0)
      return DIR_NONE;
    else if (!wrap)
      return (off > 0) ? DIR_PLUS : DIR_MINUS;
    else if (2 * mag == RADIX)
      return DIR_PLUS;
    else if (2 * mag > RADIX)
      return (off > 0) ? DIR_MINUS : DIR_PLUS;
    else
      return (off > 0) ? DIR_PLUS : DIR_MINUS;
  endfunction

  int rel_off;

  always_comb begin
    rel_off = int'(dst_c) - int'(own_c);
    dir     = pick_dir(rel_off, wrap_en);
  end

endmodule

// File: rtl/dor_port_pick.sv
module dor_port_pick
  import dor_route_pkg::*;
(
  input  step_dir_e x_dir,
  input  step_dir_e y_dir,
  output out_port_e port
);

  always_comb begin
    unique case (x_dir)
      DIR_PLUS:  port = PORT_XP;
      DIR_MINUS: port = PORT_XN;
      default: begin
        unique case (y_dir)
          DIR_PLUS:  port = PORT_YP;
          DIR_MINUS: port = PORT_YN;
          default:   port = PORT_LOCAL;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/dor_route_unit.sv
module dor_route_unit
  import dor_route_pkg::*;
#(
  parameter int RADIX = 8,
  parameter int CW    = (RADIX > 1) ? $clog2(RADIX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic          torus_mode,
  input  logic [CW-1:0] here_x,
  input  logic [CW-1:0] here_y,
  input  logic [CW-1:0] dest_x,
  input  logic [CW-1:0] dest_y,
  output logic          port_valid,
  output logic [2:0]    port_sel
);

  logic [CW-1:0] own_v [NUM_DIMS];
  logic [CW-1:0] dst_v [NUM_DIMS];
  step_dir_e     dir_v [NUM_DIMS];

  assign own_v[0] = here_x;
  assign own_v[1] = here_y;
  assign dst_v[0] = dest_x;
  assign dst_v[1] = dest_y;

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_axis
    dor_axis_dir #(.RADIX(RADIX), .CW(CW)) u_axis (
      .own_c   (own_v[d]),
      .dst_c   (dst_v[d]),
      .wrap_en (torus_mode),
      .dir     (dir_v[d])
    );
  end

  // Named internal events for the checker.
  step_dir_e x_dir;
  step_dir_e y_dir;
  out_port_e next_port;

  assign x_dir = dir_v[0];
  assign y_dir = dir_v[1];

  dor_port_pick u_pick (
    .x_dir (x_dir),
    .y_dir (y_dir),
    .port  (next_port)
  );

  out_port_e port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_valid <= 1'b0;
      port_q     <= PORT_LOCAL;
    end else begin
      port_valid <= head_valid;
      if (head_valid) port_q <= next_port;
    end
  end

  assign port_sel = port_q;

endmodule

// File: rtl/dor_route_chk.sv
module dor_route_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          head_valid,
  input logic          torus_mode,
  input logic [CW-1:0] here_x,
  input logic [CW-1:0] here_y,
  input logic [CW-1:0] dest_x,
  input logic [CW-1:0] dest_y,
  input logic          port_valid,
  input logic [2:0]    port_sel,
  input logic [1:0]    x_dir
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!port_valid && port_sel == 3'd0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid |=> port_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |=> !port_valid);

  // R9
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |=> $stable(port_sel));

  // R3
  x_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && here_x != dest_x) |=> (port_sel == 3'd1 || port_sel == 3'd2));

  // R3
  x_dir_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && x_dir != 2'd0) |=> (port_sel == {1'b0, $past(x_dir)}));

  // R4
  y_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && here_x == dest_x && here_y != dest_y) |=>
      (port_sel == 3'd3 || port_sel == 3'd4));

  // R5
  local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && here_x == dest_x && here_y == dest_y) |=> port_sel == 3'd0);

  // R6
  mesh_plus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !torus_mode && dest_x > here_x) |=> port_sel == 3'd1);

  // R6
  mesh_minus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !torus_mode && dest_x < here_x) |=> port_sel == 3'd2);

endmodule

bind dor_route_unit dor_route_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .head_valid (head_valid),
  .torus_mode (torus_mode),
  .here_x     (here_x),
  .here_y     (here_y),
  .dest_x     (dest_x),
  .dest_y     (dest_y),
  .port_valid (port_valid),
  .port_sel   (port_sel),
  .x_dir      (x_dir)
);

// File: tb/sim_dor_route_unit.sv
`timescale 1ns/1ps
module sim_dor_route_unit;

  localparam int K  = 8;
  localparam int CW = 3;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic head_valid = 1'b0;
  logic torus_mode = 1'b0;
  logic [CW-1:0] here_x = '0, here_y = '0, dest_x = '0, dest_y = '0;
  logic port_valid;
  logic [2:0] port_sel;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dor_route_unit #(.RADIX(K), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .torus_mode(torus_mode),
    .here_x(here_x), .here_y(here_y), .dest_x(dest_x), .dest_y(dest_y),
    .port_valid(port_valid), .port_sel(port_sel)
  );

  // {torus, here_x, here_y, dest_x, dest_y, expected port}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 3'd2, 3'd2, 3'd5, 3'd7, 3'd1},  // R3 R6
    {1'b0, 3'd5, 3'd1, 3'd0, 3'd6, 3'd2},  // R3 R6
    {1'b0, 3'd3, 3'd3, 3'd3, 3'd6, 3'd3},  // R4
    {1'b0, 3'd3, 3'd6, 3'd3, 3'd0, 3'd4},  // R4
    {1'b0, 3'd4, 3'd4, 3'd4, 3'd4, 3'd0},  // R5
    {1'b0, 3'd0, 3'd0, 3'd7, 3'd0, 3'd1},  // R6 no wrap
    {1'b1, 3'd0, 3'd0, 3'd7, 3'd0, 3'd2},  // R7
    {1'b1, 3'd0, 3'd0, 3'd4, 3'd0, 3'd1},  // R8
    {1'b1, 3'd4, 3'd0, 3'd0, 3'd0, 3'd1},  // R8
    {1'b1, 3'd3, 3'd7, 3'd3, 3'd1, 3'd3},  // R7
    {1'b1, 3'd2, 3'd2, 3'd4, 3'd2, 3'd1},  // R10
    {1'b1, 3'd6, 3'd5, 3'd6, 3'd1, 3'd3},  // R8
    {1'b1, 3'd1, 3'd1, 3'd6, 3'd6, 3'd2}   // R7
  };

  // Shortest-ring model: count steps each way round.
  function automatic logic [1:0] axis_model(input logic t, input int h, input int d);
    int up, dn;
    up = (d - h + K) % K;
    dn = (h - d + K) % K;
    if (up == 0) return 2'd0;
    if (!t) return (d > h) ? 2'd1 : 2'd2;
    return (up <= dn) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [2:0] port_model(input logic t, input int hx, input int hy,
                                             input int dx, input int dy);
    logic [1:0] a;
    a = axis_model(t, hx, dx);
    if (a != 2'd0) return {1'b0, a};
    a = axis_model(t, hy, dy);
    if (a == 2'd1) return 3'd3;
    if (a == 2'd2) return 3'd4;
    return 3'd0;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic route(input logic t, input int hx, input int hy, input int dx, input int dy);
    @(negedge clk);
    head_valid = 1'b1;
    torus_mode = t;
    here_x = CW'(hx); here_y = CW'(hy); dest_x = CW'(dx); dest_y = CW'(dy);
    @(negedge clk);
  endtask

  task automatic req_of(input logic t, input int hx, input int hy, input int dx, input int dy,
                        output string r);
    int ax, mag;
    ax = (hx != dx) ? dx - hx : dy - hy;
    mag = (ax < 0) ? -ax : ax;
    if (hx == dx && hy == dy) r = "R5";
    else if (!t) r = (hx != dx) ? "R3/R6" : "R4/R6";
    else if (2 * mag == K) r = "R8";
    else if (2 * mag > K) r = "R7";
    else r = "R10";
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    string r;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(port_valid == 1'b0, "R1", port_valid, 0);
    check(port_sel == 3'd0, "R1", port_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(port_valid == 1'b0 && port_sel == 3'd0, "R1", port_sel, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      route(VEC[i][15], int'(VEC[i][14:12]), int'(VEC[i][11:9]),
            int'(VEC[i][8:6]), int'(VEC[i][5:3]));
      req_of(VEC[i][15], int'(VEC[i][14:12]), int'(VEC[i][11:9]),
             int'(VEC[i][8:6]), int'(VEC[i][5:3]), r);
      check(port_sel == VEC[i][2:0], r, port_sel, VEC[i][2:0]);
      check(port_valid == 1'b1, "R2", port_valid, 1);
    end

    // R9: hold with head_valid low while coordinates move
    route(1'b0, 1, 1, 5, 1);
    check(port_sel == 3'd1, "R3", port_sel, 1);
    head_valid = 1'b0;
    here_x = 3'd6; dest_x = 3'd6; dest_y = 3'd0;
    @(negedge clk);
    check(port_valid == 1'b0, "R2", port_valid, 0);
    check(port_sel == 3'd1, "R9", port_sel, 1);
    torus_mode = 1'b1; here_y = 3'd7;
    @(negedge clk);
    check(port_sel == 3'd1, "R9", port_sel, 1);

    // Sweeps: every X pair (Y differs) and every Y pair (X equal), both modes
    for (int t = 0; t < 2; t++) begin
      for (int a = 0; a < K; a++) begin
        for (int b = 0; b < K; b++) begin
          route(t[0], a, 2, b, 6);
          req_of(t[0], a, 2, b, 6, r);
          check(port_sel == port_model(t[0], a, 2, b, 6), r, port_sel,
                port_model(t[0], a, 2, b, 6));
          route(t[0], 5, a, 5, b);
          req_of(t[0], 5, a, 5, b, r);
          check(port_sel == port_model(t[0], 5, a, 5, b), r, port_sel,
                port_model(t[0], 5, a, 5, b));
        end
      end
    end

    // R1: reset again after activity
    @(negedge clk);
    rst_n = 1'b0;
    head_valid = 1'b1;
    @(negedge clk);
    check(port_valid == 1'b0 && port_sel == 3'd0, "R1", port_sel, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule